// File: doc/BRIEF.md
# Image luminance profile accumulator

The block takes a raster stream of 8-bit RGB pixels, one pixel per clock while the pixel strobe is high. Each pixel is converted to an 8-bit luminance with a two-stage integer pipeline. The luminance is then added into two on-chip profile memories. One memory holds a sum per column (indexed by x) and the other holds a sum per row (indexed by y). Once a frame is complete, the profiles show where the picture is bright along each axis. They serve as a coarse locator for features such as spot grids or edges in a downstream image-analysis step.

An internal raster counter assigns each accepted pixel its x and y position. The counter is bounded by programmable column and row limits. It is armed by a frame-start pulse and stops by itself on the last pixel of the frame. A sweep clears both memories. The sweep runs after reset and again on request. A combinational read port returns any column or row sum.

Top module: `lum_profile_acc`

## Requirements
- R1: For each accepted pixel, `lum_out` equals (77·R + 150·G + 29·B) >> 8. It is presented with `lum_vld` high in the second cycle after the clock edge that accepted the pixel. `lum_vld` is low in every other cycle.
- R2: Pixels are accepted in raster order. x starts at 0 and rises by one per accepted pixel. When x equals `x_max`, it returns to 0 and y rises by one. Each luminance is added to column word x and to row word y of that pixel.
- R3: Pixels accepted on consecutive clocks that share a row address, or a column address, all reach the sum. No update is lost.
- R4: `frame_done` is a one-cycle pulse. It coincides with `lum_vld` of the pixel at (`x_max`, `y_max`). After that pixel the counter stops. Further pixels produce no `lum_vld` and change no sum until the next `frame_start`.
- R5: After reset, and after each `clr_req` pulse, `clr_busy` is high for exactly 2^XW cycles. At the end of that time every column and row word reads zero. Pixels presented while `clr_busy` is high are ignored.
- R6: `rd_data` returns, combinationally, column word `rd_addr` when `rd_sel` is 0. When `rd_sel` is 1 it returns row word `rd_addr[YW-1:0]`.
- R7: Without a clear, the sums of a new frame add onto the contents left by earlier frames.
- R8: Pixels presented before any `frame_start` are ignored.
- R9: A `frame_start` pulse returns x and y to 0 and arms the counter. A pixel strobed in the same cycle as `frame_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also starts a clear sweep |
| clr_req | input | 1 | Pulse that starts a clear sweep of both memories |
| frame_start | input | 1 | Pulse that zeroes x and y and arms the raster counter |
| x_max | input | XW | Last column index of the frame |
| y_max | input | YW | Last row index of the frame |
| pix_vld | input | 1 | Pixel strobe |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| lum_out | output | 8 | Luminance of the pixel accepted two edges earlier |
| lum_vld | output | 1 | `lum_out` is valid |
| frame_done | output | 1 | Last pixel of the frame is being accumulated |
| clr_busy | output | 1 | Clear sweep in progress |
| rd_sel | input | 1 | Read select: 0 column memory, 1 row memory |
| rd_addr | input | XW | Read address |
| rd_data | output | DW | Selected profile word |

## Verification
Luminance and `frame_done` are due in the second sampling point after the accepting edge. The bench runs a two-entry delay line per cycle and compares the oldest entry against the outputs at every falling edge. Each memory word is written on the edge after its luminance is shown, so profile words are read back only after several idle cycles. The read data is sampled one time step after the address is applied, with no clock in between. The clear length is counted in falling edges from the first cycle with `clr_busy` high.

// File: rtl/lum_pkg.sv
package lum_pkg;
    localparam logic [7:0] LUM_CR = 8'd77;
    localparam logic [7:0] LUM_CG = 8'd150;
    localparam logic [7:0] LUM_CB = 8'd29;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;
endpackage

// File: rtl/lum_convert.sv
module lum_convert
    import lum_pkg::*;
#(
    parameter int TAGW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  rgb_t            in_px,
    input  logic [TAGW-1:0] in_tag,
    output logic            out_vld,
    output logic [7:0]      out_lum,
    output logic [TAGW-1:0] out_tag
);
    typedef struct packed {
        logic            s1_vld;
        logic [15:0]     pr;
        logic [15:0]     pg;
        logic [15:0]     pb;
        logic [TAGW-1:0] s1_tag;
        logic            s2_vld;
        logic [15:0]     sum;
        logic [TAGW-1:0] s2_tag;
    } cv_st_t;

    cv_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = in_vld;
        st_d.pr     = 16'(LUM_CR) * 16'(in_px.r);
        st_d.pg     = 16'(LUM_CG) * 16'(in_px.g);
        st_d.pb     = 16'(LUM_CB) * 16'(in_px.b);
        st_d.s1_tag = in_tag;
        st_d.s2_vld = st_q.s1_vld;
        st_d.sum    = st_q.pr + st_q.pg + st_q.pb;
        st_d.s2_tag = st_q.s1_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.s2_vld;
    assign out_lum = st_q.sum[15:8];
    assign out_tag = st_q.s2_tag;
endmodule

// File: rtl/raster_addr.sv
module raster_addr #(
    parameter int XW = 6,
    parameter int YW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          step,
    input  logic [XW-1:0] x_max,
    input  logic [YW-1:0] y_max,
    output logic          accept,
    output logic          last,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y
);
    typedef struct packed {
        logic          run;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } ra_st_t;

    ra_st_t st_d, st_q;
    logic   x_end, y_end;

    always_comb begin
        st_d   = st_q;
        x_end  = (st_q.x == x_max);
        y_end  = (st_q.y == y_max);
        accept = step && st_q.run && !start;
        last   = accept && x_end && y_end;
        if (start) begin
            st_d.run = 1'b1;
            st_d.x   = '0;
            st_d.y   = '0;
        end else if (accept) begin
            if (x_end) begin
                st_d.x = '0;
                if (y_end) begin
                    st_d.run = 1'b0;
                end else begin
                    st_d.y = st_q.y + YW'(1);
                end
            end else begin
                st_d.x = st_q.x + XW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign x = st_q.x;
    assign y = st_q.y;
endmodule

// File: rtl/profile_ram.sv
module profile_ram #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra_acc,
    output logic [DW-1:0] rd_acc,
    input  logic [AW-1:0] ra_ext,
    output logic [DW-1:0] rd_ext
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rd_acc = mem[ra_acc];
    assign rd_ext = mem[ra_ext];
endmodule

// File: rtl/lum_profile_acc.sv
module lum_profile_acc
    import lum_pkg::*;
#(
    parameter int XW = 6,
    parameter int YW = 5,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_req,
    input  logic          frame_start,
    input  logic [XW-1:0] x_max,
    input  logic [YW-1:0] y_max,
    input  logic          pix_vld,
    input  logic [7:0]    pix_r,
    input  logic [7:0]    pix_g,
    input  logic [7:0]    pix_b,
    output logic [7:0]    lum_out,
    output logic          lum_vld,
    output logic          frame_done,
    output logic          clr_busy,
    input  logic          rd_sel,
    input  logic [XW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int TAGW = 1 + YW + XW;

    typedef struct packed {
        logic          clr;
        logic [XW-1:0] cnt;
    } cl_st_t;

    cl_st_t cl_d, cl_q;

    logic            acc_ok, acc_last;
    logic [XW-1:0]   cur_x;
    logic [YW-1:0]   cur_y;
    logic [TAGW-1:0] tag_out;
    logic            t_last;
    logic [XW-1:0]   t_x;
    logic [YW-1:0]   t_y;
    logic [DW-1:0]   col_old, row_old, col_ext, row_ext;
    logic [DW-1:0]   col_new, row_new;
    logic            col_we, row_we;
    logic [XW-1:0]   col_wa;
    logic [YW-1:0]   row_wa;
    rgb_t            px;

    // clear sweep: one word of each memory per cycle
    always_comb begin
        cl_d = cl_q;
        if (clr_req) begin
            cl_d.clr = 1'b1;
            cl_d.cnt = '0;
        end else if (cl_q.clr) begin
            cl_d.cnt = cl_q.cnt + XW'(1);
            if (cl_q.cnt == {XW{1'b1}}) begin
                cl_d.clr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cl_q <= '{clr: 1'b1, cnt: '0};
        end else begin
            cl_q <= cl_d;
        end
    end

    raster_addr #(.XW(XW), .YW(YW)) i_raster (
        .clk    (clk),
        .rst    (rst),
        .start  (frame_start),
        .step   (pix_vld && !cl_q.clr),
        .x_max  (x_max),
        .y_max  (y_max),
        .accept (acc_ok),
        .last   (acc_last),
        .x      (cur_x),
        .y      (cur_y)
    );

    assign px = '{r: pix_r, g: pix_g, b: pix_b};

    lum_convert #(.TAGW(TAGW)) i_conv (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (acc_ok),
        .in_px   (px),
        .in_tag  ({acc_last, cur_y, cur_x}),
        .out_vld (lum_vld),
        .out_lum (lum_out),
        .out_tag (tag_out)
    );

    assign {t_last, t_y, t_x} = tag_out;

    // read-add-write; the combinational read sees the previous edge's write
    always_comb begin
        col_we  = cl_q.clr || lum_vld;
        row_we  = cl_q.clr || lum_vld;
        col_wa  = cl_q.clr ? cl_q.cnt : t_x;
        row_wa  = cl_q.clr ? cl_q.cnt[YW-1:0] : t_y;
        col_new = cl_q.clr ? '0 : col_old + DW'(lum_out);
        row_new = cl_q.clr ? '0 : row_old + DW'(lum_out);
    end

    profile_ram #(.AW(XW), .DW(DW)) i_col_ram (
        .clk    (clk),
        .we     (col_we),
        .waddr  (col_wa),
        .wdata  (col_new),
        .ra_acc (t_x),
        .rd_acc (col_old),
        .ra_ext (rd_addr),
        .rd_ext (col_ext)
    );

    profile_ram #(.AW(YW), .DW(DW)) i_row_ram (
        .clk    (clk),
        .we     (row_we),
        .waddr  (row_wa),
        .wdata  (row_new),
        .ra_acc (t_y),
        .rd_acc (row_old),
        .ra_ext (rd_addr[YW-1:0]),
        .rd_ext (row_ext)
    );

    assign frame_done = lum_vld && t_last;
    assign clr_busy   = cl_q.clr;
    assign rd_data    = rd_sel ? row_ext : col_ext;
endmodule

// File: rtl/lum_profile_chk.sv
module lum_profile_chk (
    input logic clk,
    input logic rst,
    input logic pix_vld,
    input logic lum_vld,
    input logic frame_done,
    input logic clr_busy
);
    // R4: the done pulse rides on a valid luminance
    a_r4_done_with_lum: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> lum_vld);

    // R4: done lasts one cycle
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R4: the counter has stopped, so no luminance directly follows done
    a_r4_no_lum_after_done: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !lum_vld);

    // R1: a luminance needs a strobed pixel two cycles earlier
    a_r1_lum_latency: assert property (@(posedge clk) disable iff (rst)
        lum_vld |-> $past(pix_vld, 2));

    // R5: nothing presented during a clear reaches the output
    a_r5_clear_blocks: assert property (@(posedge clk) disable iff (rst)
        lum_vld |-> !$past(clr_busy, 2));
endmodule

bind lum_profile_acc lum_profile_chk i_lum_profile_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_vld    (pix_vld),
    .lum_vld    (lum_vld),
    .frame_done (frame_done),
    .clr_busy   (clr_busy)
);

// File: tb/test_lum_profile_acc.sv
module test_lum_profile_acc;
    localparam int XW = 6;
    localparam int YW = 5;
    localparam int DW = 32;
    localparam int NC = 2 ** XW;
    localparam int NR = 2 ** YW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr_req = 1'b0;
    logic          frame_start = 1'b0;
    logic [XW-1:0] x_max = '0;
    logic [YW-1:0] y_max = '0;
    logic          pix_vld = 1'b0;
    logic [7:0]    pix_r = '0, pix_g = '0, pix_b = '0;
    logic [7:0]    lum_out;
    logic          lum_vld, frame_done, clr_busy;
    logic          rd_sel = 1'b0;
    logic [XW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;

    lum_profile_acc #(.XW(XW), .YW(YW), .DW(DW)) i_lum_profile_acc (
        .clk(clk), .rst(rst), .clr_req(clr_req), .frame_start(frame_start),
        .x_max(x_max), .y_max(y_max), .pix_vld(pix_vld),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .lum_out(lum_out), .lum_vld(lum_vld), .frame_done(frame_done),
        .clr_busy(clr_busy), .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    int  col_ref [NC];
    int  row_ref [NR];
    bit  run_m = 1'b0;
    int  xm = 0, ym = 0;
    bit  p0v = 0, p0d = 0, p1v = 0, p1d = 0;
    int  p0l = 0, p1l = 0;

    function automatic int lum_of(int r, int g, int b);
        return (77 * r + 150 * g + 29 * b) >> 8;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: check due outputs, drive inputs, advance the model
    task automatic step(bit v, int r, int g, int b, bit st);
        bit acc, lst;
        int l;
        @(negedge clk);
        chk("R1 lum_vld", lum_vld, p1v);
        if (p1v) chk("R1 lum_out", lum_out, p1l);
        chk("R4 frame_done", frame_done, p1v && p1d);
        pix_vld = v; pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
        frame_start = st;
        acc = v && run_m && !st;
        l = lum_of(r, g, b);
        lst = 1'b0;
        if (st) begin
            run_m = 1'b1; xm = 0; ym = 0;
        end else if (acc) begin
            col_ref[xm] += l;
            row_ref[ym] += l;
            if (xm == int'(x_max)) begin
                xm = 0;
                if (ym == int'(y_max)) begin
                    run_m = 1'b0; lst = 1'b1;
                end else ym++;
            end else xm++;
        end
        p1v = p0v; p1l = p0l; p1d = p0d;
        p0v = acc; p0l = l; p0d = lst;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    task automatic readback(string req);
        for (int a = 0; a < NC; a++) begin
            @(negedge clk);
            rd_sel = 1'b0; rd_addr = XW'(a);
            #1 chk({req, " column"}, rd_data, col_ref[a]);
        end
        for (int a = 0; a < NR; a++) begin
            @(negedge clk);
            rd_sel = 1'b1; rd_addr = XW'(a);
            #1 chk({req, " row"}, rd_data, row_ref[a]);
        end
    endtask

    task automatic count_clear(string req);
        int c = 0;
        while (clr_busy) begin
            c++;
            @(negedge clk);
        end
        chk(req, c, NC);
        for (int a = 0; a < NC; a++) col_ref[a] = 0;
        for (int a = 0; a < NR; a++) row_ref[a] = 0;
    endtask

    task automatic frame(int xl, int yl, bit gaps, int seed);
        int np;
        x_max = XW'(xl); y_max = YW'(yl);
        step(0, 0, 0, 0, 1);
        np = (xl + 1) * (yl + 1);
        for (int i = 0; i < np; i++) begin
            step(1, (i * 37 + seed) % 256, (i * 91 + 5 * seed) % 256, (i * 53 + 200) % 256, 0);
            if (gaps && (i % 3 == 1)) idle(1);
        end
        idle(4);
    endtask

    initial begin
        for (int a = 0; a < NC; a++) col_ref[a] = 0;
        for (int a = 0; a < NR; a++) row_ref[a] = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset lum_vld", lum_vld, 0);
        chk("R4 reset frame_done", frame_done, 0);
        chk("R5 reset clr_busy", clr_busy, 1);
        rst = 1'b0;
        count_clear("R5 reset sweep length");
        readback("R5 zero after reset");

        // R8: pixels before any frame_start
        for (int i = 0; i < 5; i++) step(1, 200, 100, 50, 0);
        idle(4);
        readback("R8 unarmed");

        // R1 known colours, R3 back-to-back pixels on one row
        x_max = XW'(3); y_max = YW'(1);
        step(1, 255, 255, 255, 1);          // R9: strobe with start is ignored
        step(1, 255, 0, 0, 0);
        step(1, 0, 255, 0, 0);
        step(1, 0, 0, 255, 0);
        step(1, 255, 255, 255, 0);
        step(1, 0, 0, 0, 0);
        step(1, 10, 20, 30, 0);
        step(1, 128, 64, 32, 0);
        step(1, 1, 2, 3, 0);
        idle(4);
        chk("R1 red constant", col_ref[0], 76);
        readback("R3 back-to-back");
        readback("R9 start cycle ignored");

        // R7: second frame on top, with gaps
        frame(5, 2, 1, 17);
        readback("R7 accumulate");

        // R4: pixels after the last one are ignored
        for (int i = 0; i < 4; i++) step(1, 90, 90, 90, 0);
        idle(4);
        readback("R4 stopped");

        // R5: requested clear
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
        count_clear("R5 request sweep length");
        p0v = 0; p1v = 0;
        readback("R5 zero after request");

        // R2: full-size frame, R6 read select
        frame(NC - 1, NR - 1, 1, 3);
        readback("R2 full raster");
        readback("R6 read port");

        // R4: single-pixel frame
        frame(0, 0, 0, 99);
        readback("R4 single pixel");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule